// File: doc/BRIEF.md
# Priority-Level Interrupt Controller

This block gathers thirteen peripheral interrupt request lines, numbered 1 to 13, and turns them into one interrupt level and one vector byte for the processor. Each request line is copied into a pending register on every clock. A mask register blocks chosen sources. Each source also has its own control byte. That byte holds a five-bit priority code and a flag that selects an automatic vector.

Of the sources that are pending and not masked, the one with the largest priority code wins. The top three bits of its code are the processor interrupt level. The vector is either a fixed automatic value derived from that level, or a value read from a vector register. Sources 12 and 13 (the two serial ports) each have a dedicated vector register. All other sources share one software vector register. Sources 9 and 10 are normally wired to the two timers. Configuration arrives over a simple single-cycle write port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every source is masked, nothing is pending, all control bytes are zero and `irq_level` is 0, even when sources are raised.
- R2: Pending bit i takes the value of `src_in[i]` at each rising clock edge. Raising an input sets the bit and lowering it clears the bit.
- R3: A source is active only when its pending bit is 1 and its mask bit is 0. A mask bit of 1 blocks that source.
- R4: The winner is the active source with the largest priority code, which is bits 4:0 of its control byte. A source whose code is 0 never wins.
- R5: When active sources tie on the largest code, the lowest-numbered of them wins.
- R6: `irq_level` equals bits 4:2 of the winner's code, or 0 when there is no winner.
- R7: When bit 7 of the winner's control byte is 1, `irq_vector` equals 24 plus `irq_level`.
- R8: When bit 7 of the winner's control byte is 0, `irq_vector` comes from the port-A vector register if the winner is source 12, from the port-B vector register if it is source 13, and from the software vector register otherwise.
- R9: A write with `wr_en` high is decoded by `wr_addr` as follows: address 0 loads the mask from `wr_data[13:1]` (bit i masks source i); addresses 1 to 13 load that source's control byte from `wr_data[7:0]`; address 14 loads the software vector; address 15 loads the port-A vector; address 16 loads the port-B vector (vectors from `wr_data[7:0]`). The effect shows on the outputs after the same single clock edge as a pending change.
- R10: A write to any address from 17 to 31 changes no state and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_in | input | 13 | Request lines; bit i is source i (i = 1..13) |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 5 | Configuration register select |
| wr_data | input | 14 | Configuration write data |
| irq_level | output | 3 | Interrupt level to the processor, 0 when no source wins |
| irq_vector | output | 8 | Vector for the winning source; meaningful only when `irq_level` is nonzero |

## Verification
Two events can land on the same clock edge: a change on the request lines and a configuration write. For example, a source may rise in the very cycle that its mask bit or its control byte is rewritten. The random phase drives new request values and a write in most cycles, with priority codes drawn from a narrow set so that ties happen often. After each edge, a bench model first applies both the new pending value and the write, then picks a winner by a linear scan. Level and vector are compared against this model one edge after the stimulus. Directed cases cover masking at reset, code zero, ties, the three vector sources, the automatic vector and writes to unused addresses.

// File: rtl/prio_irq_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the priority-level interrupt controller.
// Assumes a five-bit priority code whose upper bits form the level.
package prio_irq_pkg;

    localparam int CODE_W   = 5;            // priority code width
    localparam int LVL_W    = CODE_W - 2;   // level = code[4:2]
    localparam int VEC_W    = 8;            // vector byte width
    localparam int AV_BIT   = 7;            // autovector flag position in control byte

    // Stored part of a source control byte (unused bits are not kept)
    typedef struct packed {
        logic              autovec;
        logic [CODE_W-1:0] code;
    } src_ctrl_t;

endpackage

// File: rtl/prio_irq_regs.sv
`timescale 1ns/1ps
// Configuration and pending storage for the interrupt controller.
// Holds the pending copy of the request lines, the mask, one control
// entry per source and the three vector registers. Writes are decoded
// from a flat address: 0 mask, 1..NUM_SRC control, then software,
// port-A and port-B vectors. Other addresses are ignored.
module prio_irq_regs
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 14
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_SRC:1]       src_in,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    output logic [NUM_SRC:1]       pend,
    output logic [NUM_SRC:1]       mask,
    output src_ctrl_t [NUM_SRC:1]  ctrl,
    output logic [VEC_W-1:0]       sw_vec,
    output logic [VEC_W-1:0]       pa_vec,
    output logic [VEC_W-1:0]       pb_vec
);

    localparam int ADDR_MASK = 0;
    localparam int ADDR_SW   = NUM_SRC + 1;
    localparam int ADDR_PA   = NUM_SRC + 2;
    localparam int ADDR_PB   = NUM_SRC + 3;

    logic wr_mask, wr_sw, wr_pa, wr_pb;

    // Decode the non-indexed write targets
    always_comb begin
        wr_mask = wr_en && (wr_addr == ADDR_W'(ADDR_MASK));
        wr_sw   = wr_en && (wr_addr == ADDR_W'(ADDR_SW));
        wr_pa   = wr_en && (wr_addr == ADDR_W'(ADDR_PA));
        wr_pb   = wr_en && (wr_addr == ADDR_W'(ADDR_PB));
    end

    // Pending register follows the request lines each cycle
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= src_in;
    end

    // Mask register: all sources blocked out of reset
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '1;
        else if (wr_mask) mask <= wr_data[NUM_SRC:1];
    end

    // Per-source control entries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            for (int i = 1; i <= NUM_SRC; i++) begin
                if (wr_en && (wr_addr == ADDR_W'(i))) begin
                    ctrl[i].autovec <= wr_data[AV_BIT];
                    ctrl[i].code    <= wr_data[CODE_W-1:0];
                end
            end
        end
    end

    // Vector registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_vec <= '0;
            pa_vec <= '0;
            pb_vec <= '0;
        end else begin
            if (wr_sw) sw_vec <= wr_data[VEC_W-1:0];
            if (wr_pa) pa_vec <= wr_data[VEC_W-1:0];
            if (wr_pb) pb_vec <= wr_data[VEC_W-1:0];
        end
    end

    assert_pend_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pend == $past(src_in)));

    assert_mask_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mask == '1) && (pend == '0));

    assert_mask_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (mask == $past(wr_data[NUM_SRC:1])));

endmodule

// File: rtl/prio_irq_pick.sv
`timescale 1ns/1ps
// Winner selection by a balanced comparison tree.
// Leaves are source numbers padded to a power of two; each node keeps
// the left (lower-numbered) candidate unless the right one is valid and
// strictly larger, which yields lowest-number-wins on equal codes.
// A source with code 0 is never a candidate.
module prio_irq_pick
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int IDX_W   = $clog2(NUM_SRC + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SRC:1]               active,
    input  logic [NUM_SRC:1][CODE_W-1:0]   code,
    output logic                           win_valid,
    output logic [IDX_W-1:0]               win_idx,
    output logic [CODE_W-1:0]              win_code
);

    localparam int LEAVES = 1 << IDX_W;
    localparam int NODES  = 2 * LEAVES;

    logic              nv [1:NODES-1];
    logic [CODE_W-1:0] nc [1:NODES-1];
    logic [IDX_W-1:0]  ni [1:NODES-1];

    for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
        if (k >= 1 && k <= NUM_SRC) begin : g_real
            assign nv[LEAVES+k] = active[k] && (code[k] != '0);
            assign nc[LEAVES+k] = code[k];
            assign ni[LEAVES+k] = IDX_W'(k);
        end else begin : g_pad
            assign nv[LEAVES+k] = 1'b0;
            assign nc[LEAVES+k] = '0;
            assign ni[LEAVES+k] = IDX_W'(k);
        end
    end

    for (genvar n = 1; n < LEAVES; n++) begin : g_node
        logic take_r;
        assign take_r = nv[2*n+1] && (!nv[2*n] || (nc[2*n+1] > nc[2*n]));
        assign nv[n]  = nv[2*n] || nv[2*n+1];
        assign nc[n]  = take_r ? nc[2*n+1] : nc[2*n];
        assign ni[n]  = take_r ? ni[2*n+1] : ni[2*n];
    end

    assign win_valid = nv[1];
    assign win_idx   = ni[1];
    assign win_code  = nc[1];

    // Independent linear scan used only by the checks below
    logic beat_hi, beat_tie, any_cand;
    always_comb begin
        beat_hi  = 1'b0;
        beat_tie = 1'b0;
        any_cand = 1'b0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            if (active[i] && code[i] != '0) begin
                any_cand = 1'b1;
                if (code[i] > win_code) beat_hi = 1'b1;
                if (code[i] == win_code && IDX_W'(i) < win_idx) beat_tie = 1'b1;
            end
        end
    end

    assert_win_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> active[win_idx] && (code[win_idx] == win_code));

    assert_win_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (any_cand == win_valid) && !(win_valid && beat_hi));

    assert_tie_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> !beat_tie);

endmodule

// File: rtl/prio_irq_vec.sv
`timescale 1ns/1ps
// Level and vector formation for the selected source.
// Level is the top bits of the winning code, 0 without a winner.
// Vector is the automatic value (base + level) or one of three
// vector registers chosen by the winning source number.
module prio_irq_vec
    import prio_irq_pkg::*;
#(
    parameter int IDX_W        = 4,
    parameter int PORT_A_SRC   = 12,
    parameter int PORT_B_SRC   = 13,
    parameter int AUTOVEC_BASE = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                win_valid,
    input  logic [IDX_W-1:0]    win_idx,
    input  logic [LVL_W-1:0]    win_lvl,
    input  logic                win_autovec,
    input  logic [VEC_W-1:0]    sw_vec,
    input  logic [VEC_W-1:0]    pa_vec,
    input  logic [VEC_W-1:0]    pb_vec,
    output logic [LVL_W-1:0]    irq_level,
    output logic [VEC_W-1:0]    irq_vector
);

    // Level from the winner, zero when idle
    always_comb begin
        irq_level = win_valid ? win_lvl : '0;
    end

    // Vector source selection
    always_comb begin
        if (win_autovec)
            irq_vector = VEC_W'(AUTOVEC_BASE) + VEC_W'(irq_level);
        else if (win_idx == IDX_W'(PORT_A_SRC))
            irq_vector = pa_vec;
        else if (win_idx == IDX_W'(PORT_B_SRC))
            irq_vector = pb_vec;
        else
            irq_vector = sw_vec;
    end

    assert_autovec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && win_autovec) |-> (irq_vector >= VEC_W'(AUTOVEC_BASE)));

    assert_port_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !win_autovec && win_idx == IDX_W'(PORT_B_SRC)) |-> (irq_vector == pb_vec));

endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
// Priority-level interrupt controller top.
// Collects request lines into pending state, applies the mask, selects
// the highest-priority active source and drives level and vector.
// Outputs are combinational from registered state, so any change on
// inputs or configuration appears one clock edge later.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC      = 13,
    parameter int ADDR_W       = 5,
    parameter int DATA_W       = 14,
    parameter int PORT_A_SRC   = 12,
    parameter int PORT_B_SRC   = 13,
    parameter int AUTOVEC_BASE = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC:1]    src_in,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [2:0]          irq_level,
    output logic [7:0]          irq_vector
);

    localparam int IDX_W = $clog2(NUM_SRC + 1);

    logic [NUM_SRC:1]              pend, mask, active;
    src_ctrl_t [NUM_SRC:1]         ctrl;
    logic [NUM_SRC:1][CODE_W-1:0]  codes;
    logic [VEC_W-1:0]              sw_vec, pa_vec, pb_vec;
    logic                          win_valid, win_autovec;
    logic [IDX_W-1:0]              win_idx;
    logic [CODE_W-1:0]             win_code;

    prio_irq_regs #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_in  (src_in),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pend    (pend),
        .mask    (mask),
        .ctrl    (ctrl),
        .sw_vec  (sw_vec),
        .pa_vec  (pa_vec),
        .pb_vec  (pb_vec)
    );

    // Active set and code vector for the selection tree
    always_comb begin
        active = pend & ~mask;
        for (int i = 1; i <= NUM_SRC; i++) codes[i] = ctrl[i].code;
    end

    prio_irq_pick #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .code      (codes),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_code  (win_code)
    );

    // Autovector flag of the winning source
    always_comb begin
        win_autovec = 1'b0;
        for (int i = 1; i <= NUM_SRC; i++)
            if (win_idx == IDX_W'(i)) win_autovec = ctrl[i].autovec;
    end

    prio_irq_vec #(
        .IDX_W        (IDX_W),
        .PORT_A_SRC   (PORT_A_SRC),
        .PORT_B_SRC   (PORT_B_SRC),
        .AUTOVEC_BASE (AUTOVEC_BASE)
    ) u_vec (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_valid   (win_valid),
        .win_idx     (win_idx),
        .win_lvl     (win_code[CODE_W-1:2]),
        .win_autovec (win_autovec),
        .sw_vec      (sw_vec),
        .pa_vec      (pa_vec),
        .pb_vec      (pb_vec),
        .irq_level   (irq_level),
        .irq_vector  (irq_vector)
    );

    assert_level_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> (active != '0) && (win_code >= CODE_W'(4)));

    assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |-> (irq_level == '0));

endmodule

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [13:1] src_in;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [13:0] wr_data;
    logic [2:0]  irq_level;
    logic [7:0]  irq_vector;

    always #2.5 clk = ~clk;

    prio_irq_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_in     (src_in),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .irq_level  (irq_level),
        .irq_vector (irq_vector)
    );

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    // Bench model of the requirements
    logic [13:1] m_pend, m_mask;
    logic [7:0]  m_ctrl [1:13];
    logic [7:0]  m_sw, m_pa, m_pb;

    function automatic void model_reset();
        m_pend = '0;
        m_mask = '1;
        for (int i = 1; i <= 13; i++) m_ctrl[i] = '0;
        m_sw = '0; m_pa = '0; m_pb = '0;
    endfunction

    function automatic void model_write(input logic [4:0] a, input logic [13:0] d);
        if (a == 5'd0)                    m_mask = d[13:1];
        else if (a >= 5'd1 && a <= 5'd13) m_ctrl[a] = d[7:0];
        else if (a == 5'd14)              m_sw = d[7:0];
        else if (a == 5'd15)              m_pa = d[7:0];
        else if (a == 5'd16)              m_pb = d[7:0];
    endfunction

    function automatic void model_out(output logic [2:0] l, output logic [7:0] v);
        int best = 0;
        logic [4:0] bc = 5'd0;
        for (int i = 1; i <= 13; i++)
            if (m_pend[i] && !m_mask[i] && m_ctrl[i][4:0] > bc) begin
                best = i;
                bc   = m_ctrl[i][4:0];
            end
        l = bc[4:2];
        if (best == 0)              v = 8'h00;
        else if (m_ctrl[best][7])   v = 8'd24 + {5'd0, l};
        else if (best == 12)        v = m_pa;
        else if (best == 13)        v = m_pb;
        else                        v = m_sw;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, model the edge, compare at next negedge
    task automatic cyc(input logic [13:1] s, input bit we, input logic [4:0] a,
                       input logic [13:0] d, input string tag);
        logic [2:0] el;
        logic [7:0] ev;
        src_in  = s;
        wr_en   = we;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        m_pend = s;
        if (we) model_write(a, d);
        @(negedge clk);
        wr_en = 1'b0;
        model_out(el, ev);
        chk(tag, {5'd0, irq_level}, {5'd0, el});
        if (el != 3'd0) chk(tag, irq_vector, ev);
    endtask

    function automatic logic [13:0] cb(input bit av, input logic [4:0] code);
        return {6'd0, av, 2'd0, code};
    endfunction

    function automatic logic [13:1] sb(input int i);
        return 13'(1) << (i - 1);
    endfunction

    initial begin
        int unused_seed;
        logic [13:1] s;
        logic [13:0] d;
        logic [4:0]  a;
        rst_n = 1'b0; src_in = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", {5'd0, irq_level}, 8'd0);

        // R1: raised source stays blocked while reset mask holds
        cyc(sb(5), 1, 5'd5, cb(0, 5'd28), "R1");
        chk("R1", {5'd0, irq_level}, 8'd0);
        // R3: unmask all, source 5 now wins at level 7
        cyc(sb(5), 1, 5'd0, 14'd0, "R3");
        chk("R3", {5'd0, irq_level}, 8'd7);
        // R3: mask only source 5
        cyc(sb(5), 1, 5'd0, 14'(sb(5)) << 1, "R3");
        chk("R3", {5'd0, irq_level}, 8'd0);
        cyc(sb(5), 1, 5'd0, 14'd0, "R3");
        // R2: lowering the line clears pending
        cyc('0, 0, 5'd0, 14'd0, "R2");
        chk("R2", {5'd0, irq_level}, 8'd0);
        // R4: code 0 never wins
        cyc(sb(2), 0, 5'd0, 14'd0, "R4");
        chk("R4", {5'd0, irq_level}, 8'd0);
        cyc(sb(2) | sb(5), 1, 5'd2, cb(0, 5'd8), "R4");
        chk("R4", {5'd0, irq_level}, 8'd7);
        // R4 / R7: larger code with autovector takes over
        cyc(sb(2) | sb(5), 1, 5'd2, cb(1, 5'd29), "R7");
        chk("R7", irq_vector, 8'd31);
        // R5 / R8: tie between ports, lower number wins
        cyc('0, 1, 5'd15, 14'h51, "R8");
        cyc('0, 1, 5'd16, 14'h52, "R8");
        cyc('0, 1, 5'd12, cb(0, 5'd20), "R5");
        cyc(sb(12) | sb(13), 1, 5'd13, cb(0, 5'd20), "R5");
        chk("R5", irq_vector, 8'h51);
        chk("R6", {5'd0, irq_level}, 8'd5);
        cyc(sb(12) | sb(13), 1, 5'd0, 14'(sb(12)) << 1, "R8");
        chk("R8", irq_vector, 8'h52);
        cyc(sb(12) | sb(13), 1, 5'd14, 14'h40, "R8");
        cyc(sb(3) | sb(13), 1, 5'd3, cb(0, 5'd21), "R8");
        chk("R8", irq_vector, 8'h40);
        // R10: unused address leaves everything unchanged
        cyc(sb(3) | sb(13), 1, 5'd20, 14'h3FFF, "R10");
        chk("R10", irq_vector, 8'h40);
        chk("R10", {5'd0, irq_level}, 8'd5);
        cyc(sb(3) | sb(13), 1, 5'd31, 14'h3FFF, "R10");
        chk("R10", irq_vector, 8'h40);
        // R9: control write visible after one edge
        cyc(sb(3) | sb(13), 1, 5'd3, cb(1, 5'd31), "R9");
        chk("R9", irq_vector, 8'd31);

        // Random phase, input changes and writes often share an edge
        unused_seed = $urandom(32'd20240607);
        for (int n = 0; n < 4000; n++) begin
            s = 13'($urandom & $urandom);
            a = 5'($urandom % 21);
            d = 14'($urandom);
            if (a == 5'd0) d = 14'($urandom & $urandom & $urandom);
            if (a >= 5'd1 && a <= 5'd13)
                d[4:0] = {3'($urandom_range(0, 7)), 1'b0, 1'($urandom % 2)};
            cyc(s, ($urandom % 3) != 0, a, d, "R6");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule